// File: doc/BRIEF.md
# DMA Channel Enable Register with Set/Clear Writes

This block is a memory-mapped 16-bit control register that holds the enables for a group of DMA channels. The channels are bit-plane fetch, a display coprocessor, a block-transfer engine, sprites, disk and four audio channels. Software does not overwrite the register. Instead, each write carries a mode bit in bit 15. Every other data bit that is 1 then either sets or clears the matching stored bit, and every data bit that is 0 leaves its stored bit alone. As a result, independent pieces of software can switch their own channels on and off without a read-modify-write sequence.

The register is written at one bus address and read at another. A read returns the stored enables and two live flags from the block-transfer engine: busy, and all-zero result. The block also drives the effective per-channel enables, each gated by a stored master enable. It drives a steal-inhibit output as well, which keeps the processor from taking bus cycles while the block-transfer engine runs with raised priority. Arbitration, the DMA engines and the producers of the status flags lie outside the block.

Top module: `dma_enable_ctl`

## Requirements
- R1: A write at the write address with data bit 15 = 1 sets to 1 every stored bit (positions 10..0) whose data bit is 1.
- R2: A write at the write address with data bit 15 = 0 clears to 0 every stored bit (positions 10..0) whose data bit is 1.
- R3: In both modes, stored bits whose data bit is 0 keep their value.
- R4: Data bits 14..11 of a write have no effect on any stored bit or output.
- R5: A read at the read address returns stored bits 10..0 in bits 10..0, the live busy flag in bit 14 and the live zero flag in bit 13. Bits 15, 12 and 11 read as 0.
- R6: A write at any address other than the write address leaves the register unchanged. Read data is 0 unless a read at the read address is in progress.
- R7: Bit 9 is the master enable. Effective enable output bit i (i = 0..8: audio 0-3 on 0-3, disk 4, sprite 5, block-transfer 6, coprocessor 7, bit-plane 8) is stored bit i AND stored bit 9.
- R8: The steal-inhibit output is high exactly when the following are all true: stored bit 10 (priority), the effective block-transfer enable (bit 6 gated by bit 9), and the live busy flag.
- R9: A synchronous reset clears all stored bits, so every effective enable, the master output and steal-inhibit are 0.
- R10: Outputs follow the stored value, so a write changes them only after the clock edge that accepts it. During the write cycle they still reflect the previous contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| busAddr | input | ADDR_W | Register address of the current access |
| busWr | input | 1 | Write strobe |
| busWrData | input | 16 | Write data, bit 15 selects set (1) or clear (0) |
| busRd | input | 1 | Read strobe |
| busRdData | output | 16 | Read data, 0 when not reading this register |
| xferBusy | input | 1 | Live busy flag of the block-transfer engine |
| xferZero | input | 1 | Live all-zero flag of the block-transfer engine |
| chanOn | output | 9 | Effective per-channel enables |
| masterOn | output | 1 | Stored master enable |
| stealInhibit | output | 1 | Blocks processor bus-cycle stealing |

## Verification
Two events can land in one cycle. The first is a write that alters the priority, master or block-transfer bits. The second is a live busy flag that already drives steal-inhibit from the old contents. The bench raises busy and then issues a write that clears the priority bit. In the write cycle, before the edge, it checks that steal-inhibit and the enables still show the old contents. After the edge it checks that they show the new contents. The same comparison runs for every write of a long arithmetic sweep of data patterns, set/clear modes and status-flag values, against a model of the register kept in the bench.

// File: rtl/dma_enable_pkg.sv
package dma_enable_pkg;
  localparam int DATA_W     = 16;
  localparam int BIT_MODE   = 15;
  localparam int BIT_BUSY   = 14;
  localparam int BIT_ZERO   = 13;
  localparam int BIT_PRIO   = 10;
  localparam int BIT_MASTER = 9;
  localparam int BIT_XFER   = 6;
  localparam int NUM_CHAN   = BIT_MASTER;
  localparam int CTL_W      = BIT_PRIO + 1;

  typedef struct packed {
    logic wrSet;
    logic wrClr;
    logic rdSel;
  } strobe_t;
endpackage

// File: rtl/dma_enable_decode.sv
module dma_enable_decode
  import dma_enable_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter logic [ADDR_W-1:0] WR_ADDR = 9'h040,
  parameter logic [ADDR_W-1:0] RD_ADDR = 9'h042
) (
  input  logic              busWr,
  input  logic              busRd,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              modeBit,
  output strobe_t           strb
);
  logic wrHit;
  logic rdHit;

  always_comb begin
    wrHit      = busWr && (busAddr == WR_ADDR);
    rdHit      = busRd && (busAddr == RD_ADDR);
    strb.wrSet = wrHit && modeBit;
    strb.wrClr = wrHit && !modeBit;
    strb.rdSel = rdHit;
  end
endmodule

// File: rtl/dma_enable_core.sv
module dma_enable_core
  import dma_enable_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  strobe_t           strb,
  input  logic [CTL_W-1:0]  wrMask,
  input  logic              xferBusy,
  input  logic              xferZero,
  output logic [CTL_W-1:0]  ctlQ,
  output logic [DATA_W-1:0] rdData,
  output logic [NUM_CHAN-1:0] chanOn,
  output logic              masterOn,
  output logic              stealInhibit
);
  genvar i;

  generate
    for (i = 0; i < CTL_W; i++) begin : g_bit
      always_ff @(posedge clk) begin
        if (rst)
          ctlQ[i] <= 1'b0;
        else if (strb.wrSet && wrMask[i])
          ctlQ[i] <= 1'b1;
        else if (strb.wrClr && wrMask[i])
          ctlQ[i] <= 1'b0;
      end
    end

    for (i = 0; i < NUM_CHAN; i++) begin : g_gate
      assign chanOn[i] = ctlQ[i] & ctlQ[BIT_MASTER];
    end
  endgenerate

  assign masterOn     = ctlQ[BIT_MASTER];
  assign stealInhibit = ctlQ[BIT_PRIO] & chanOn[BIT_XFER] & xferBusy;

  always_comb begin
    rdData = '0;
    if (strb.rdSel) begin
      rdData[CTL_W-1:0] = ctlQ;
      rdData[BIT_BUSY]  = xferBusy;
      rdData[BIT_ZERO]  = xferZero;
    end
  end
endmodule

// File: rtl/dma_enable_ctl.sv
module dma_enable_ctl
  import dma_enable_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter logic [ADDR_W-1:0] WR_ADDR = 9'h040,
  parameter logic [ADDR_W-1:0] RD_ADDR = 9'h042
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic [15:0]       busWrData,
  input  logic              busRd,
  output logic [15:0]       busRdData,
  input  logic              xferBusy,
  input  logic              xferZero,
  output logic [8:0]        chanOn,
  output logic              masterOn,
  output logic              stealInhibit
);
  strobe_t          strb;
  logic [CTL_W-1:0] ctlQ;
  logic             unusedHi;

  assign unusedHi = ^busWrData[BIT_MODE-1:CTL_W];

  dma_enable_decode #(
    .ADDR_W (ADDR_W),
    .WR_ADDR(WR_ADDR),
    .RD_ADDR(RD_ADDR)
  ) u_dec (
    .busWr  (busWr),
    .busRd  (busRd),
    .busAddr(busAddr),
    .modeBit(busWrData[BIT_MODE]),
    .strb   (strb)
  );

  dma_enable_core u_core (
    .clk         (clk),
    .rst         (rst),
    .strb        (strb),
    .wrMask      (busWrData[CTL_W-1:0]),
    .xferBusy    (xferBusy),
    .xferZero    (xferZero),
    .ctlQ        (ctlQ),
    .rdData      (busRdData),
    .chanOn      (chanOn),
    .masterOn    (masterOn),
    .stealInhibit(stealInhibit)
  );
endmodule

// File: rtl/dma_enable_chk.sv
module dma_enable_chk #(
  parameter int ADDR_W = 9,
  parameter logic [ADDR_W-1:0] WR_ADDR = 9'h040
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWr,
  input logic [15:0]       busWrData,
  input logic [15:0]       busRdData,
  input logic              xferBusy,
  input logic [8:0]        chanOn,
  input logic              stealInhibit,
  input logic [10:0]       ctlQ
);
  logic wrHit;
  assign wrHit = busWr && (busAddr == WR_ADDR);

  AST_SET_BITS: assert property (@(posedge clk) disable iff (rst)
    (wrHit && busWrData[15]) |=> ((ctlQ & $past(busWrData[10:0])) == $past(busWrData[10:0]))); // R1
  AST_CLR_BITS: assert property (@(posedge clk) disable iff (rst)
    (wrHit && !busWrData[15]) |=> ((ctlQ & $past(busWrData[10:0])) == 11'd0)); // R2
  AST_KEEP_ZERO_BITS: assert property (@(posedge clk) disable iff (rst)
    wrHit |=> (((ctlQ ^ $past(ctlQ)) & ~$past(busWrData[10:0])) == 11'd0)); // R3
  AST_NO_STRAY_WRITE: assert property (@(posedge clk) disable iff (rst)
    !wrHit |=> $stable(ctlQ)); // R6
  AST_UNUSED_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    (busRdData[15] == 1'b0) && (busRdData[12:11] == 2'b00)); // R5
  AST_MASTER_GATES: assert property (@(posedge clk) disable iff (rst)
    !ctlQ[9] |-> (chanOn == 9'd0)); // R7
  AST_INHIBIT_NEEDS_BUSY: assert property (@(posedge clk) disable iff (rst)
    stealInhibit |-> (xferBusy && ctlQ[10])); // R8
  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (ctlQ == 11'd0)); // R9
endmodule

bind dma_enable_ctl dma_enable_chk #(
  .ADDR_W (ADDR_W),
  .WR_ADDR(WR_ADDR)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .busAddr     (busAddr),
  .busWr       (busWr),
  .busWrData   (busWrData),
  .busRdData   (busRdData),
  .xferBusy    (xferBusy),
  .chanOn      (chanOn),
  .stealInhibit(stealInhibit),
  .ctlQ        (ctlQ)
);

// File: tb/sim_dma_enable_ctl.sv
`timescale 1ns/1ps
module sim_dma_enable_ctl;
  localparam logic [8:0] WA = 9'h040;
  localparam logic [8:0] RA = 9'h042;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [8:0]  busAddr = '0;
  logic        busWr = 1'b0;
  logic [15:0] busWrData = '0;
  logic        busRd = 1'b0;
  logic [15:0] busRdData;
  logic        xferBusy = 1'b0;
  logic        xferZero = 1'b0;
  logic [8:0]  chanOn;
  logic        masterOn;
  logic        stealInhibit;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  logic [10:0] model = '0;

  always #2 clk = ~clk;

  dma_enable_ctl #(.ADDR_W(9), .WR_ADDR(WA), .RD_ADDR(RA)) u0 (
    .clk(clk), .rst(rst), .busAddr(busAddr), .busWr(busWr),
    .busWrData(busWrData), .busRd(busRd), .busRdData(busRdData),
    .xferBusy(xferBusy), .xferZero(xferZero), .chanOn(chanOn),
    .masterOn(masterOn), .stealInhibit(stealInhibit)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [8:0] expChan(input logic [10:0] m);
    return m[9] ? m[8:0] : 9'd0;
  endfunction

  // R7 / R8 outputs against the model
  task automatic chkOutputs(input string tag);
    chk({tag, " R7 chanOn"}, {23'd0, chanOn}, {23'd0, expChan(model)});
    chk({tag, " R7 masterOn"}, {31'd0, masterOn}, {31'd0, model[9]});
    chk({tag, " R8 stealInhibit"}, {31'd0, stealInhibit},
        {31'd0, model[10] & model[9] & model[6] & xferBusy});
  endtask

  // R5 read format
  task automatic readCheck(input string tag);
    @(negedge clk);
    busAddr = RA; busRd = 1'b1;
    #1;
    chk({tag, " R5 read"}, {16'd0, busRdData},
        {16'd0, 1'b0, xferBusy, xferZero, 2'b00, model});
    busRd = 1'b0;
  endtask

  // R1 R2 R3 R4 write with model update; R10 checked inside the write cycle
  task automatic doWrite(input logic [8:0] a, input logic [15:0] d);
    @(negedge clk);
    busAddr = a; busWr = 1'b1; busWrData = d;
    #1;
    chkOutputs("R10 write cycle");
    @(negedge clk);
    busWr = 1'b0;
    if (a == WA) begin
      if (d[15]) model = model | d[10:0];
      else       model = model & ~d[10:0];
    end
    #1;
    chkOutputs("after write");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    // R9 reset state
    chk("R9 chanOn", {23'd0, chanOn}, 32'd0);
    chk("R9 masterOn", {31'd0, masterOn}, 32'd0);
    chk("R9 stealInhibit", {31'd0, stealInhibit}, 32'd0);
    readCheck("R9");

    // R6 read data idle
    #1;
    chk("R6 idle read", {16'd0, busRdData}, 32'd0);

    // R1 R2 single-bit walk
    for (int i = 0; i < 11; i++) begin
      doWrite(WA, 16'h8000 | (16'd1 << i));
      readCheck("R1 walk set");
    end
    for (int i = 0; i < 11; i++) begin
      doWrite(WA, 16'd1 << i);
      readCheck("R2 walk clr");
    end

    // R4 high data bits ignored
    doWrite(WA, 16'hF800);
    xferBusy = 1'b1; xferZero = 1'b1;
    readCheck("R4 set hi");
    xferBusy = 1'b0;
    readCheck("R4 busy live");
    xferZero = 1'b0;

    // R6 write elsewhere has no effect
    doWrite(WA, 16'h87FF);
    doWrite(RA, 16'h07FF);
    readCheck("R6 stray clear");
    doWrite(9'h041, 16'h07FF);
    readCheck("R6 stray clear2");
    busAddr = RA;
    #1;
    chk("R6 no strobe", {16'd0, busRdData}, 32'd0);

    // R10 concurrency: busy high, clear priority in the same cycle
    xferBusy = 1'b1;
    #1;
    chk("R8 inhibit on", {31'd0, stealInhibit}, 32'd1);
    doWrite(WA, 16'h0400);
    chk("R10 inhibit off", {31'd0, stealInhibit}, 32'd0);
    doWrite(WA, 16'h8400);
    doWrite(WA, 16'h0200);
    chk("R7 master off", {23'd0, chanOn}, 32'd0);
    doWrite(WA, 16'h8200);

    // R1 R2 R3 arithmetic sweep
    for (int k = 0; k < 400; k++) begin
      logic [15:0] d;
      d = 16'((k * 16'h9E37) ^ (k << 7) ^ (k >> 3));
      d[15] = k[0] ^ k[3];
      xferBusy = k[1];
      xferZero = k[2];
      doWrite(WA, d);
      readCheck("R3 sweep");
    end

    // R9 reset from a populated state
    doWrite(WA, 16'h87FF);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    model = '0;
    #1;
    chkOutputs("R9 re-reset");
    readCheck("R9 re-reset");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule